// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the already-synchronized levels of a 32-pin port. It decides, pin by pin, whether an interrupt event has happened. Each pin can be sensitive to a level or to an edge. In edge mode, a single polarity bit picks a falling or a rising transition. In level mode, the same bit picks the active-high or active-low level. A dual-edge bit makes an edge-mode pin trigger on both transitions.

Each event sets a sticky bit in a pending-status register. Software reads that register and clears bits by writing ones to a separate clear address. Two masks are supplied as input vectors, one for interrupts and one for wakeup. They gate the pending bits into a single interrupt request and a single power-management wake request.

Configuration uses a small write/read register port with a combinational read path. The register offsets, relative to the block base, are:

| Register | Offset |
|----------|--------|
| sensitivity mode | 0x00 |
| polarity | 0x04 |
| dual-edge | 0x08 |
| pending status | 0x0C |
| clear | 0x10 |

Pad control and output driving are handled elsewhere.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, the mode, polarity, dual-edge and status registers all read 0, and `irq_req` and `wake_req` are low.
- R2: Writes to offset 0x00 (mode), 0x04 (polarity) and 0x08 (dual-edge) take effect at the clock edge of the write and read back unchanged. A cycle without a write leaves them stable.
- R3: A pin with mode bit 1, polarity bit 0 and dual-edge bit 0 sets its status bit on a falling transition. A rising transition does not set it.
- R4: A pin with mode bit 1, polarity bit 1 and dual-edge bit 0 sets its status bit on a rising transition. A falling transition does not set it.
- R5: A pin with mode bit 1 and dual-edge bit 1 sets its status bit on both transitions, whatever its polarity bit.
- R6: A pin with mode bit 0 sets its status bit on every cycle its active level is present: high for polarity 0, low for polarity 1. A clear while that level persists leaves the bit set.
- R7: Writing a mask to offset 0x10 clears exactly the status bits where the mask is 1 and leaves every other bit unchanged. Offset 0x10 reads as 0.
- R8: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq_req` is high exactly when some status bit is 1 and its `irq_mask` bit is 1.
- R10: `wake_req` is high exactly when some status bit is 1 and its `wake_mask` bit is 1.
- R11: The dual-edge bit has no effect on a pin in level mode.
- R12: The status register at offset 0x0C is read-only. A write to it changes no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | 32 | Synchronized pin levels |
| irq_mask | input | 32 | Per-pin interrupt enable |
| wake_mask | input | 32 | Per-pin wake enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake request |

## Verification
A wrong previous-level sample or a wrong sensitivity decode shows at the ports in the next cycle after the triggering pin change. It appears as a status bit that is missing or extra on a read of offset 0x0C, and through the masks as an `irq_req` or `wake_req` that is wrong. Errors in the clear path appear in the cycle after the clear write. A bit that survives a clear, or a neighbouring bit that disappears, is visible on the next status read. The clear-versus-event collision and the level-persistence case are placed so that a design which gives priority to the clear reads back 0 where 1 is expected.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and register decode for the GPIO pin interrupt detector.
// Assumes byte offsets on an 8-bit address and one data bit per pin.
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DUAL = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_POL,
        SEL_DUAL,
        SEL_STAT,
        SEL_CLR
    } reg_sel_e;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MODE: decode_addr = SEL_MODE;
            OFS_POL:  decode_addr = SEL_POL;
            OFS_DUAL: decode_addr = SEL_DUAL;
            OFS_STAT: decode_addr = SEL_STAT;
            OFS_CLR:  decode_addr = SEL_CLR;
            default:  decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
// Configuration store: per-pin sensitivity mode, polarity and dual-edge bits.
// A write through the register port loads the selected word at the clock edge.
// Assumes the selector is already decoded from the address.
module gpio_irq_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] mode,
    output logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] dual
);

    localparam int unsigned NUM_CFG = 3;

    logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg_q;
    logic [NUM_CFG-1:0]               hit;

    // Which configuration word the current write targets.
    always_comb begin
        hit[0] = wr && (sel == SEL_MODE);
        hit[1] = wr && (sel == SEL_POL);
        hit[2] = wr && (sel == SEL_DUAL);
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        // Load one configuration word on write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      cfg_q[g] <= '0;
            else if (hit[g]) cfg_q[g] <= wdata;
        end
    end

    assign mode = cfg_q[0];
    assign pol  = cfg_q[1];
    assign dual = cfg_q[2];

    // R2: without a write the configuration stays put.
    a_r2_cfg_stable : assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(mode) && $stable(pol) && $stable(dual)));

endmodule

// File: rtl/gpio_irq_pin_detect.sv
// Per-pin event detector. Keeps each pin's level from one clock earlier.
// Edge mode: a transition selected by polarity or dual-edge is an event.
// Level mode: the active level is an event on every cycle it is present.
// Assumes pin_level is already synchronized to clk.
module gpio_irq_pin_detect #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] mode,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] dual,
    output logic [NUM_PINS-1:0] evt
);

    logic [NUM_PINS-1:0] prev_q;

    // Remember the previous pin level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_level;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;

        // Classify this pin's condition under its configuration.
        always_comb begin
            rise      = pin_level[i] && !prev_q[i];
            fall      = !pin_level[i] && prev_q[i];
            edge_hit  = dual[i] ? (rise || fall) : (pol[i] ? rise : fall);
            level_hit = pol[i] ? !pin_level[i] : pin_level[i];
            evt[i]    = mode[i] ? edge_hit : level_hit;
        end

        // R3: an edge-mode event needs a level change since the last cycle.
        a_r3_edge_needs_change : assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && evt[i]) |-> (pin_level[i] != prev_q[i]));
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Pending-status register with write-one-to-clear and event priority.
// Also gates status through the interrupt and wake masks into requests.
// Assumes clr is already qualified by a write to the clear offset.
module gpio_irq_status #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt,
    input  logic [NUM_PINS-1:0] clr,
    input  logic [NUM_PINS-1:0] irq_mask,
    input  logic [NUM_PINS-1:0] wake_mask,
    output logic [NUM_PINS-1:0] status,
    output logic                irq_req,
    output logic                wake_req
);

    logic [NUM_PINS-1:0] status_q;

    // Clear the requested bits, then let new events set theirs.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | evt;
    end

    // Merge pending bits through each mask into one request line.
    always_comb begin
        irq_req  = |(status_q & irq_mask);
        wake_req = |(status_q & wake_mask);
    end

    assign status = status_q;

    // R8: any event in the previous cycle is pending now.
    a_r8_event_wins : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(evt)) == $past(evt)));

    // R7: a cleared bit without a coincident event reads 0.
    a_r7_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(clr) & ~$past(evt)) == '0));

    // R12: a status bit only drops when it was cleared.
    a_r12_drop_needs_clear : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~status_q & $past(status_q) & ~$past(clr)) == '0));

    // R9: no pending bit means no interrupt request.
    a_r9_irq_needs_status : assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq_req);

    // R10: no pending bit means no wake request.
    a_r10_wake_needs_status : assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !wake_req);

endmodule

// File: rtl/gpio_irq_detect.sv
// Top of the GPIO pin interrupt detector. Decodes the register port, holds
// the configuration, detects per-pin events and keeps the pending status.
// Assumes synchronized pins and one write per cycle; reads are combinational.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] irq_mask,
    input  logic [NUM_PINS-1:0] wake_mask,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq_req,
    output logic                wake_req
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] mode, pol, dual, evt, clr_vec, status;

    // Decode the register offset and form the clear mask.
    always_comb begin
        sel     = decode_addr(reg_addr);
        clr_vec = (reg_wr && sel == SEL_CLR) ? reg_wdata : '0;
    end

    gpio_irq_cfg_regs #(.NUM_PINS(NUM_PINS)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .sel   (sel),
        .wdata (reg_wdata),
        .mode  (mode),
        .pol   (pol),
        .dual  (dual)
    );

    gpio_irq_pin_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .mode      (mode),
        .pol       (pol),
        .dual      (dual),
        .evt       (evt)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .clr       (clr_vec),
        .irq_mask  (irq_mask),
        .wake_mask (wake_mask),
        .status    (status),
        .irq_req   (irq_req),
        .wake_req  (wake_req)
    );

    // Select the read word; clear and unmapped offsets read as zero.
    always_comb begin
        case (sel)
            SEL_MODE: reg_rdata = mode;
            SEL_POL:  reg_rdata = pol;
            SEL_DUAL: reg_rdata = dual;
            SEL_STAT: reg_rdata = status;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_level = '0, irq_mask = '0, wake_mask = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0C;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req, wake_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gpio_irq_detect i_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .irq_mask(irq_mask),
        .wake_mask(wake_mask), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .wake_req(wake_req)
    );

    // Row: {pins, clear mask, expected status}. Config: pins 0..2 edge mode,
    // pol 1 on pins 1 and 4, dual on pins 2 and 5; pins 3..5 level mode.
    localparam logic [95:0] STEPS [0:19] = '{
        {32'h11, 32'h00, 32'h00},  // R3 rise ignored on pin0
        {32'h10, 32'h00, 32'h01},  // R3 fall sets pin0
        {32'h12, 32'h00, 32'h03},  // R4 rise sets pin1
        {32'h10, 32'h00, 32'h03},  // R4 fall ignored on pin1
        {32'h10, 32'h03, 32'h00},  // R7 clear both
        {32'h14, 32'h00, 32'h04},  // R5 rise on dual pin2
        {32'h10, 32'h04, 32'h04},  // R5 R8 fall plus clear: event wins
        {32'h10, 32'h04, 32'h00},  // R7 clear pin2
        {32'h18, 32'h00, 32'h08},  // R6 high level pin3
        {32'h18, 32'h08, 32'h08},  // R6 clear while level persists
        {32'h10, 32'h08, 32'h00},  // R6 clear after level gone
        {32'h00, 32'h00, 32'h10},  // R6 low level pin4
        {32'h10, 32'h10, 32'h00},  // R6 R7 clear after pin4 high
        {32'h30, 32'h00, 32'h20},  // R11 high level pin5 with dual set
        {32'h10, 32'h20, 32'h00},  // R11 falling does not set level pin
        {32'h11, 32'h00, 32'h00},  // R3 rise ignored
        {32'h10, 32'h00, 32'h01},  // R3 fall
        {32'h12, 32'h00, 32'h03},  // R4 rise
        {32'h12, 32'h01, 32'h02},  // R7 partial clear keeps pin1
        {32'h12, 32'h02, 32'h00}   // R7 clear pin1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'h0C;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
        reg_addr = 8'h0C;
    endtask

    task automatic step(input logic [31:0] pins, input logic [31:0] clr);
        @(negedge clk);
        pin_level = pins;
        if (clr != 0) begin reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = clr; end
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'h0C;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        irq_mask = '1; wake_mask = '1;
        #0.5;
        // R1 reset state
        reg_read(8'h00, rd); check("R1 mode", rd, 0);
        reg_read(8'h04, rd); check("R1 pol", rd, 0);
        reg_read(8'h08, rd); check("R1 dual", rd, 0);
        reg_read(8'h0C, rd); check("R1 status", rd, 0);
        check("R1 irq", {31'b0, irq_req}, 0);
        check("R1 wake", {31'b0, wake_req}, 0);
        irq_mask = '0; wake_mask = '0;

        reg_write(8'h00, 32'h07);
        reg_write(8'h04, 32'h12);
        reg_write(8'h08, 32'h24);
        reg_read(8'h00, rd); check("R2 mode", rd, 32'h07);
        reg_read(8'h04, rd); check("R2 pol", rd, 32'h12);
        reg_read(8'h08, rd); check("R2 dual", rd, 32'h24);
        reg_read(8'h10, rd); check("R7 clear reads zero", rd, 0);

        step(32'h10, 0); step(32'h10, 0);
        step(32'h10, 32'hFFFF_FFFF);
        reg_read(8'h0C, rd); check("R7 clear all", rd, 0);

        for (int i = 0; i < 20; i++) begin
            step(STEPS[i][95:64], STEPS[i][63:32]);
            reg_read(8'h0C, rd);
            check($sformatf("row %0d (R3 R4 R5 R6 R7 R8 R11)", i), rd, STEPS[i][31:0]);
        end

        // Build status 0x03 for mask checks
        step(32'h10, 0); step(32'h11, 0); step(32'h10, 0); step(32'h12, 0);
        reg_read(8'h0C, rd); check("R9 setup status", rd, 32'h03);
        irq_mask = 32'h02; wake_mask = 32'h01; #0.5;
        check("R9 irq masked hit", {31'b0, irq_req}, 1);
        check("R10 wake masked hit", {31'b0, wake_req}, 1);
        irq_mask = 32'h04; wake_mask = 32'h0; #0.5;
        check("R9 irq masked off", {31'b0, irq_req}, 0);
        check("R10 wake masked off", {31'b0, wake_req}, 0);

        // R12 write to status offset is ignored
        reg_write(8'h0C, 32'h0);
        reg_read(8'h0C, rd); check("R12 status read-only", rd, 32'h03);
        reg_read(8'h00, rd); check("R2 stable after other write", rd, 32'h07);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1; pin_level = '0;
        irq_mask = '1; wake_mask = '1; #0.5;
        reg_read(8'h0C, rd); check("R1 status after reset", rd, 0);
        reg_read(8'h00, rd); check("R1 mode after reset", rd, 0);
        check("R1 irq after reset", {31'b0, irq_req}, 0);

        finish_run();
    end

endmodule